// File: doc/BRIEF.md
# Hypercube Dimension-Order Routing Node

This block is one node of a binary hypercube network with 2^DIMS processing elements. It has one local port, through which its own processing element injects and receives messages, and DIMS neighbour ports. Neighbour port d is wired to the node whose identifier is this node's identifier with bit d inverted. Each message carries a destination identifier, a hop counter and a payload.

Each input keeps at most one message in a holding slot. A held message goes to the local port when its destination is this node's identifier. Otherwise it crosses the lowest-numbered dimension in which the destination and this node still differ. Each hop clears one differing bit, so a message reaches its destination after as many hops as the two identifiers have differing bits. When several held messages want the same output, the input with the lowest index wins. The others wait in their slots. A message leaves its slot only when the output it wants signals ready.

Top module: `hcube_router`

## Requirements
- R1: Port index 0 is the local port. Port index d+1 (0 <= d < DIMS) is the link across dimension d, to the node whose identifier differs from NODE_ID only in bit d. The same numbering applies to inputs and outputs.
- R2: After reset every holding slot is empty: all `inReady` bits are 1 and all `outValid` bits are 0.
- R3: A held message whose destination equals NODE_ID is presented on output 0, with its hop count unchanged.
- R4: Any other held message is presented on output k+1, where k is the index of the least significant set bit of destination XOR NODE_ID.
- R5: A message presented on a neighbour output carries its incoming hop count plus one, modulo 2^HOP_W. For example, 15 becomes 0 when HOP_W is 4.
- R6: Each input holds one message. `inReady[i]` is 0 while slot i is full and its message is not leaving in that cycle. A message accepted at a clock edge is presented on its output in the cycle after that edge. A slot that empties in a cycle may accept a new message in that same cycle.
- R7: When several full slots want the same output, the lowest input index is presented. A losing message stays in its slot and is presented later with its content unchanged.
- R8: A presented message leaves only at an edge where its output's `outReady` is 1. While `outReady` is 0 the output stays valid.
- R9: The destination and payload fields pass through unchanged.
- R10: In a network of 2^DIMS such nodes, a message injected at node s for node t is ejected only at node t, with a hop count equal to the number of bits in which s and t differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | DIMS+1 | Per input port: a message is offered |
| inReady | output | DIMS+1 | Per input port: the slot accepts this cycle |
| inDst | input | (DIMS+1)*DIMS | Destination identifier of each input, DIMS bits per port |
| inHop | input | (DIMS+1)*HOP_W | Hop count of each input |
| inPay | input | (DIMS+1)*PAY_W | Payload of each input |
| outValid | output | DIMS+1 | Per output port: a message is presented |
| outReady | input | DIMS+1 | Per output port: the receiver takes the message |
| outDst | output | (DIMS+1)*DIMS | Destination identifier on each output |
| outHop | output | (DIMS+1)*HOP_W | Hop count on each output |
| outPay | output | (DIMS+1)*PAY_W | Payload on each output |

## Verification
The bound checker examines every cycle. It checks that a message on the local output is addressed to this node. It checks that a message on a neighbour output differs from this node in that dimension and in no lower one. It also checks that a stalled output stays valid, that a full slot always has its output presented, and that reset leaves all slots empty. The bench's scenarios cover the rest: the exact hop arithmetic including wraparound, which contender wins and that the loser's message returns intact, same-cycle refill of a draining slot, and delivery with hop count equal to the Hamming distance across a full eight-node network.

// File: rtl/hcube_pkg.sv
package hcube_pkg;

  // Default sizing of the control-to-datapath strobes (three dimensions, four ports).
  localparam int DEF_PORTS = 4;

  typedef struct packed {
    logic [DEF_PORTS-1:0][DEF_PORTS-1:0] grant;  // [output][input]
    logic [DEF_PORTS-1:0]                pop;    // slot drains this cycle
    logic [DEF_PORTS-1:0]                load;   // slot captures this cycle
  } hcStrobesDef_t;

endpackage

// File: rtl/hcube_route_calc.sv
// Picks the requested output for one held message: local when addressed here,
// else the lowest dimension still differing.
module hcube_route_calc #(
  parameter int DIMS    = 3,
  parameter int NODE_ID = 0,
  localparam int PORTS  = DIMS + 1
) (
  input  logic [DIMS-1:0]  dst,
  output logic [PORTS-1:0] req
);
  localparam logic [DIMS-1:0] SELF = DIMS'(NODE_ID);

  logic [DIMS-1:0] diff;
  assign diff = dst ^ SELF;

  always_comb begin
    req = '0;
    if (diff == '0) begin
      req[0] = 1'b1;
    end else begin
      for (int d = DIMS - 1; d >= 0; d--) begin
        if (diff[d]) begin
          req = '0;
          req[d+1] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hcube_ctrl.sv
// Fixed-priority arbitration per output and the slot handshake strobes.
module hcube_ctrl #(
  parameter int  DIMS     = 3,
  parameter type strobe_t = hcube_pkg::hcStrobesDef_t,
  localparam int PORTS    = DIMS + 1
) (
  input  logic [PORTS-1:0][PORTS-1:0] reqMat,     // [input][output]
  input  logic [PORTS-1:0]            slotValid,
  input  logic [PORTS-1:0]            inValid,
  input  logic [PORTS-1:0]            outReady,
  output logic [PORTS-1:0]            inReady,
  output strobe_t                     strobes
);
  logic [PORTS-1:0][PORTS-1:0] grantMat;  // [output][input]
  logic [PORTS-1:0]            popVec;

  for (genvar o = 0; o < PORTS; o++) begin : g_arb
    always_comb begin
      logic taken;
      taken = 1'b0;
      for (int i = 0; i < PORTS; i++) begin
        grantMat[o][i] = slotValid[i] & reqMat[i][o] & ~taken;
        taken = taken | (slotValid[i] & reqMat[i][o]);
      end
    end
  end

  for (genvar i = 0; i < PORTS; i++) begin : g_pop
    always_comb begin
      popVec[i] = 1'b0;
      for (int o = 0; o < PORTS; o++) begin
        popVec[i] = popVec[i] | (grantMat[o][i] & outReady[o]);
      end
    end
  end

  assign inReady = ~slotValid | popVec;

  always_comb begin
    strobes       = '0;
    strobes.grant = grantMat;
    strobes.pop   = popVec;
    strobes.load  = inValid & inReady;
  end
endmodule

// File: rtl/hcube_datapath.sv
// Holding slots, route lookup per slot and the output multiplexers.
module hcube_datapath #(
  parameter int  DIMS     = 3,
  parameter int  NODE_ID  = 0,
  parameter int  HOP_W    = 4,
  parameter int  PAY_W    = 16,
  parameter type strobe_t = hcube_pkg::hcStrobesDef_t,
  localparam int PORTS    = DIMS + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strobes,
  input  logic [PORTS*DIMS-1:0]      inDst,
  input  logic [PORTS*HOP_W-1:0]     inHop,
  input  logic [PORTS*PAY_W-1:0]     inPay,
  output logic [PORTS-1:0]           slotValid,
  output logic [PORTS-1:0][PORTS-1:0] reqMat,
  output logic [PORTS-1:0]           outValid,
  output logic [PORTS*DIMS-1:0]      outDst,
  output logic [PORTS*HOP_W-1:0]     outHop,
  output logic [PORTS*PAY_W-1:0]     outPay
);
  logic [PORTS-1:0][DIMS-1:0]  slotDst;
  logic [PORTS-1:0][HOP_W-1:0] slotHop;
  logic [PORTS-1:0][PAY_W-1:0] slotPay;

  for (genvar i = 0; i < PORTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slotValid[i] <= 1'b0;
        slotDst[i]   <= '0;
        slotHop[i]   <= '0;
        slotPay[i]   <= '0;
      end else if (strobes.load[i]) begin
        slotValid[i] <= 1'b1;
        slotDst[i]   <= inDst[i*DIMS +: DIMS];
        slotHop[i]   <= inHop[i*HOP_W +: HOP_W];
        slotPay[i]   <= inPay[i*PAY_W +: PAY_W];
      end else if (strobes.pop[i]) begin
        slotValid[i] <= 1'b0;
      end
    end

    hcube_route_calc #(
      .DIMS   (DIMS),
      .NODE_ID(NODE_ID)
    ) u_route (
      .dst(slotDst[i]),
      .req(reqMat[i])
    );
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_out
    logic [DIMS-1:0]  selDst;
    logic [HOP_W-1:0] selHop;
    logic [PAY_W-1:0] selPay;

    always_comb begin
      selDst = '0;
      selHop = '0;
      selPay = '0;
      for (int i = 0; i < PORTS; i++) begin
        if (strobes.grant[o][i]) begin
          selDst = selDst | slotDst[i];
          selHop = selHop | slotHop[i];
          selPay = selPay | slotPay[i];
        end
      end
    end

    assign outValid[o]               = |strobes.grant[o];
    assign outDst[o*DIMS +: DIMS]    = selDst;
    assign outPay[o*PAY_W +: PAY_W]  = selPay;
    if (o == 0) begin : g_local
      assign outHop[o*HOP_W +: HOP_W] = selHop;
    end else begin : g_link
      assign outHop[o*HOP_W +: HOP_W] = selHop + HOP_W'(1);
    end
  end
endmodule

// File: rtl/hcube_router.sv
module hcube_router #(
  parameter int DIMS    = 3,
  parameter int NODE_ID = 0,
  parameter int HOP_W   = 4,
  parameter int PAY_W   = 16,
  localparam int PORTS  = DIMS + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PORTS-1:0]       inValid,
  output logic [PORTS-1:0]       inReady,
  input  logic [PORTS*DIMS-1:0]  inDst,
  input  logic [PORTS*HOP_W-1:0] inHop,
  input  logic [PORTS*PAY_W-1:0] inPay,
  output logic [PORTS-1:0]       outValid,
  input  logic [PORTS-1:0]       outReady,
  output logic [PORTS*DIMS-1:0]  outDst,
  output logic [PORTS*HOP_W-1:0] outHop,
  output logic [PORTS*PAY_W-1:0] outPay
);
  typedef struct packed {
    logic [PORTS-1:0][PORTS-1:0] grant;
    logic [PORTS-1:0]            pop;
    logic [PORTS-1:0]            load;
  } strobe_t;

  strobe_t                     strobes;
  logic [PORTS-1:0]            slotValid;
  logic [PORTS-1:0][PORTS-1:0] reqMat;

  hcube_ctrl #(
    .DIMS    (DIMS),
    .strobe_t(strobe_t)
  ) u_ctrl (
    .reqMat   (reqMat),
    .slotValid(slotValid),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .strobes  (strobes)
  );

  hcube_datapath #(
    .DIMS    (DIMS),
    .NODE_ID (NODE_ID),
    .HOP_W   (HOP_W),
    .PAY_W   (PAY_W),
    .strobe_t(strobe_t)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inDst    (inDst),
    .inHop    (inHop),
    .inPay    (inPay),
    .slotValid(slotValid),
    .reqMat   (reqMat),
    .outValid (outValid),
    .outDst   (outDst),
    .outHop   (outHop),
    .outPay   (outPay)
  );
endmodule

// File: rtl/hcube_router_chk.sv
module hcube_router_chk #(
  parameter int DIMS    = 3,
  parameter int NODE_ID = 0,
  localparam int PORTS  = DIMS + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [PORTS-1:0]      inReady,
  input logic [PORTS-1:0]      outValid,
  input logic [PORTS-1:0]      outReady,
  input logic [PORTS*DIMS-1:0] outDst
);
  localparam logic [DIMS-1:0] SELF = DIMS'(NODE_ID);

  // R2: slots come out of reset empty
  a_r2_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&inReady && outValid == '0));

  // R3: local output only carries messages addressed here
  a_r3_eject_home: assert property (@(posedge clk) disable iff (rst)
    outValid[0] |-> outDst[DIMS-1:0] == SELF);

  for (genvar d = 0; d < DIMS; d++) begin : g_dim
    localparam logic [DIMS-1:0] BIT_D = DIMS'(1) << d;
    localparam logic [DIMS-1:0] BELOW = BIT_D - DIMS'(1);
    logic [DIMS-1:0] diffD;
    assign diffD = outDst[(d+1)*DIMS +: DIMS] ^ SELF;

    // R4: link d used only when bit d is the lowest differing bit
    a_r4_lowest_dim: assert property (@(posedge clk) disable iff (rst)
      outValid[d+1] |-> ((diffD & BIT_D) != '0 && (diffD & BELOW) == '0));
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_out
    // R8: a stalled output stays valid
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
      $past(outValid[o] && !outReady[o]) |-> outValid[o]);
  end

  for (genvar i = 0; i < PORTS; i++) begin : g_in
    // R6: a full slot always has some output presenting
    a_r6_full_is_served: assert property (@(posedge clk) disable iff (rst)
      !inReady[i] |-> (outValid != '0));
  end
endmodule

bind hcube_router hcube_router_chk #(
  .DIMS   (DIMS),
  .NODE_ID(NODE_ID)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outDst  (outDst)
);

// File: tb/hcube_router_bench.sv
module hcube_router_bench;
  localparam int DIMS  = 3;
  localparam int P     = DIMS + 1;
  localparam int HOP_W = 4;
  localparam int PAY_W = 16;
  localparam int ME    = 5;
  localparam int NN    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [P-1:0]       inValid = '0;
  logic [P-1:0]       inReady;
  logic [P*DIMS-1:0]  inDst = '0;
  logic [P*HOP_W-1:0] inHop = '0;
  logic [P*PAY_W-1:0] inPay = '0;
  logic [P-1:0]       outValid;
  logic [P-1:0]       outReady = '1;
  logic [P*DIMS-1:0]  outDst;
  logic [P*HOP_W-1:0] outHop;
  logic [P*PAY_W-1:0] outPay;

  hcube_router #(.DIMS(DIMS), .NODE_ID(ME), .HOP_W(HOP_W), .PAY_W(PAY_W)) u_hcube_router (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inDst(inDst),
    .inHop(inHop), .inPay(inPay), .outValid(outValid), .outReady(outReady),
    .outDst(outDst), .outHop(outHop), .outPay(outPay));

  // Eight-node network for R10 and R1
  logic [P-1:0]       nIV[NN], nIR[NN], nOV[NN], nOR[NN];
  logic [P*DIMS-1:0]  nID[NN], nOD[NN];
  logic [P*HOP_W-1:0] nIH[NN], nOH[NN];
  logic [P*PAY_W-1:0] nIP[NN], nOP[NN];
  logic [NN-1:0]      injValid = '0;
  logic [DIMS-1:0]    injDst = '0;
  logic [PAY_W-1:0]   injPay = '0;

  for (genvar a = 0; a < NN; a++) begin : g_node
    assign nIV[a][0]          = injValid[a];
    assign nID[a][DIMS-1:0]   = injDst;
    assign nIH[a][HOP_W-1:0]  = '0;
    assign nIP[a][PAY_W-1:0]  = injPay;
    assign nOR[a][0]          = 1'b1;
    for (genvar d = 0; d < DIMS; d++) begin : g_link
      localparam int B = a ^ (1 << d);
      assign nIV[a][d+1]                    = nOV[B][d+1];
      assign nID[a][(d+1)*DIMS +: DIMS]     = nOD[B][(d+1)*DIMS +: DIMS];
      assign nIH[a][(d+1)*HOP_W +: HOP_W]   = nOH[B][(d+1)*HOP_W +: HOP_W];
      assign nIP[a][(d+1)*PAY_W +: PAY_W]   = nOP[B][(d+1)*PAY_W +: PAY_W];
      assign nOR[a][d+1]                    = nIR[B][d+1];
    end
    hcube_router #(.DIMS(DIMS), .NODE_ID(a), .HOP_W(HOP_W), .PAY_W(PAY_W)) u_node (
      .clk(clk), .rst(rst), .inValid(nIV[a]), .inReady(nIR[a]), .inDst(nID[a]),
      .inHop(nIH[a]), .inPay(nIP[a]), .outValid(nOV[a]), .outReady(nOR[a]),
      .outDst(nOD[a]), .outHop(nOH[a]), .outPay(nOP[a]));
  end

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int oDst(input int o); return int'(outDst[o*DIMS +: DIMS]); endfunction
  function automatic int oHop(input int o); return int'(outHop[o*HOP_W +: HOP_W]); endfunction
  function automatic int oPay(input int o); return int'(outPay[o*PAY_W +: PAY_W]); endfunction

  task automatic offer(input int p, input int dst, input int hop, input int pay);
    inValid[p]                = 1'b1;
    inDst[p*DIMS +: DIMS]     = DIMS'(dst);
    inHop[p*HOP_W +: HOP_W]   = HOP_W'(hop);
    inPay[p*PAY_W +: PAY_W]   = PAY_W'(pay);
  endtask

  // {input port, destination, incoming hop, expected output, expected hop}, node id 5
  localparam int NV = 9;
  localparam int VEC[NV][5] = '{
    '{0, 5,  0, 0, 0},
    '{0, 4,  0, 1, 1},
    '{0, 7,  0, 2, 1},
    '{0, 1,  0, 3, 1},
    '{2, 2,  3, 1, 4},
    '{3, 6,  2, 1, 3},
    '{1, 1, 15, 3, 0},
    '{3, 5,  2, 0, 2},
    '{1, 3,  6, 2, 7}
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2 inReady", int'(inReady), 15);
    chk("R2 outValid", int'(outValid), 0);

    // Table walk, all outputs ready
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      offer(VEC[k][0], VEC[k][1], VEC[k][2], 16'hA000 + k);
      @(negedge clk);
      inValid = '0;
      chk(VEC[k][3] == 0 ? "R3 port" : "R4 port", int'(outValid), 1 << VEC[k][3]);
      chk("R5 hop", oHop(VEC[k][3]), VEC[k][4]);
      chk("R9 dst", oDst(VEC[k][3]), VEC[k][1]);
      chk("R9 pay", oPay(VEC[k][3]), 16'hA000 + k);
    end
    @(negedge clk);
    chk("R8 drained", int'(outValid), 0);

    // R7/R8/R6: contention and stall
    outReady = '0;
    offer(0, 4, 0, 16'h00A1);
    offer(2, 4, 1, 16'h00B2);
    @(negedge clk);
    inValid = '0;
    chk("R7 winner valid", int'(outValid), 2);
    chk("R7 winner pay", oPay(1), 16'h00A1);
    chk("R6 full input2", int'(inReady[2]), 0);
    offer(0, 5, 9, 16'h0055);
    repeat (2) @(negedge clk);
    chk("R8 stalled valid", int'(outValid[1]), 1);
    chk("R8 stalled pay", oPay(1), 16'h00A1);
    chk("R6 full input0 refuses", int'(inReady[0]), 0);
    chk("R6 refused not seen", int'(outValid[0]), 0);
    outReady = '1;
    @(negedge clk);
    inValid = '0;
    chk("R7 loser pay", oPay(1), 16'h00B2);
    chk("R7 loser hop", oHop(1), 2);
    chk("R6 refill eject", int'(outValid[0]), 1);
    chk("R6 refill pay", oPay(0), 16'h0055);
    chk("R3 refill hop", oHop(0), 9);
    @(negedge clk);
    chk("R8 all left", int'(outValid), 0);

    // R10/R1: network delivery
    for (int s = 0; s < NN; s++) begin
      int t;
      bit found;
      t = (s == 0) ? 7 : ((s * 3 + 1) & 7);
      @(negedge clk);
      injValid[s] = 1'b1;
      injDst = DIMS'(t);
      injPay = PAY_W'(16'h1000 + s);
      @(negedge clk);
      injValid = '0;
      found = 1'b0;
      for (int c = 0; c < 12 && !found; c++) begin
        for (int n = 0; n < NN; n++) begin
          if (nOV[n][0] && !found) begin
            found = 1'b1;
            chk("R10 node", n, t);
            chk("R10 hops", int'(nOH[n][HOP_W-1:0]), $countones(s ^ t));
            chk("R1 pay", int'(nOP[n][PAY_W-1:0]), 16'h1000 + s);
          end
        end
        if (!found) @(negedge clk);
      end
      chk("R10 delivered", int'(found), 1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule